// File: doc/BRIEF.md
# Slice-Striped Register Group Cast Unit

This block re-lays the bytes of a vector register group so that a group written at one element width reads correctly at another width. The register file datapath is cut into VLEN/SLEN slices, and within each register the elements are dealt round-robin across the slices. Because the element-to-byte placement therefore depends on the element width, a group that was written with one element width is scrambled when read with another. The unit applies the permutation that gives the same bytes as storing the group to memory at the source width and reloading it at the destination width.

One whole register group (up to the maximum group size) enters per beat, together with its source width code, destination width code, group size code and a layout select. The cast result is registered and leaves one cycle later behind a valid/ready handshake. A new group is accepted every cycle unless the output is stalled. A second, packed layout can be selected, where each slice holds a run of consecutive elements. It is kept so that the striped layout can be compared against it.

Top module: `slice_cast_unit`

## Requirements
- R1: While reset is held and just after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Bytes of register r, byte y sit at `in_data[(r*VLEN/8 + y)*8 +: 8]`, and elements are numbered register by register. In striped layout (`in_contig`=0), element k of a register occupies slice k mod (VLEN/SLEN) at element position k div (VLEN/SLEN). Each slice is SLEN/8 bytes, and slice 0 holds the low bytes. Width codes are 0=8, 1=16, 2=32 bits. Group codes are 0=1, 1=2, 2=4 registers.
- R3: For every pair of source and destination widths, the output byte for memory index m, placed at the destination width, equals the input byte for memory index m, placed at the source width.
- R4: When the source and destination widths are equal, the data passes unchanged with the same latency.
- R5: In packed layout (`in_contig`=1), chunks of SLEN/8 consecutive memory bytes go first down slice 0 of registers 0..LMUL-1, then down slice 1, and so on. Since this placement does not depend on the width, every cast in this layout returns the input unchanged.
- R6: Output registers at index LMUL and above are driven to zero.
- R7: Width code 3 acts as 32 bits and group code 3 acts as four registers.
- R8: With SLEN equal to VLEN, the striped layout is plain memory order and every cast is an identity.
- R9: A beat accepted at a clock edge is presented on `out_data` with `out_valid` high right after that edge. With `out_ready` held high, a new beat is accepted every cycle.
- R10: While `out_valid` is high and `out_ready` low, the output holds its data and `in_ready` is low. No beat is dropped, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat |
| in_src_eew | input | 2 | Width code the group was written with |
| in_dst_eew | input | 2 | Width code the group will be read with |
| in_lmul | input | 2 | Group size code |
| in_contig | input | 1 | 1 selects packed layout, 0 striped |
| in_data | input | VLEN*MAXLMUL | Register group, register 0 in the low bits |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | VLEN*MAXLMUL | Re-laid register group |

## Verification
The bench places a byte-by-byte known pattern in an 8-bit striped group and reads it as 32-bit elements. It then checks the bytes where a slice or register boundary falls. A design that swapped the slice and position terms, or numbered elements across the whole group instead of per register, would put the wrong element index there. Every width pair is compared against a forward model of both layouts. This catches a design that applied only one side of the permutation or inverted it, since such a design gives the transpose. Further cases cover short groups, where leftover registers must read zero rather than stale or wrapped bytes; reserved codes, which must not select a narrower width; the flat-slice instance, which must not interleave; and a stream with an irregular `out_ready`, where a design that let `in_ready` ignore the stall would lose or repeat beats.

// File: rtl/slice_cast_pkg.sv
// Shared types for the slice-striped cast unit.
// Assumes width and group codes are two bits wide.
package slice_cast_pkg;

    typedef enum logic [1:0] {
        EW_CODE_8   = 2'd0,
        EW_CODE_16  = 2'd1,
        EW_CODE_32  = 2'd2,
        EW_CODE_RSV = 2'd3
    } ew_code_e;

    // Decoded cast configuration: log2 byte widths, log2 group size, layout.
    typedef struct packed {
        logic [1:0] src_wl;
        logic [1:0] dst_wl;
        logic [1:0] grp_ll;
        logic       contig;
    } scu_cfg_t;

endpackage

// File: rtl/scu_cfg_decode.sv
// Turns raw width and group codes into clamped log2 values.
// Assumes MAX_WL and MAX_LL fit in two bits; codes above them saturate.
module scu_cfg_decode
    import slice_cast_pkg::*;
#(
    parameter int MAX_WL = 2,
    parameter int MAX_LL = 2
) (
    input  logic [1:0] src_code,
    input  logic [1:0] dst_code,
    input  logic [1:0] grp_code,
    input  logic       contig,
    output scu_cfg_t   cfg
);
    localparam logic [1:0] WL_TOP = 2'(MAX_WL);
    localparam logic [1:0] LL_TOP = 2'(MAX_LL);

    // Saturate every code to the largest supported value.
    always_comb begin
        cfg.src_wl = (src_code > WL_TOP) ? WL_TOP : src_code;
        cfg.dst_wl = (dst_code > WL_TOP) ? WL_TOP : dst_code;
        cfg.grp_ll = (grp_code > LL_TOP) ? LL_TOP : grp_code;
        cfg.contig = contig;
    end
endmodule

// File: rtl/scu_byte_map.sv
// Combinational byte permutation between two element widths.
// For each output byte it finds the memory index that the destination
// layout places there, then the input byte that the source layout uses
// for that memory index. Registers beyond the group size read zero.
// Assumes VLEN, SLEN and element byte widths are powers of two.
module scu_byte_map
    import slice_cast_pkg::*;
#(
    parameter int VLEN    = 256,
    parameter int SLEN    = 128,
    parameter int MAXLMUL = 4
) (
    input  scu_cfg_t                    cfg,
    input  logic [VLEN*MAXLMUL-1:0]     src,
    output logic [VLEN*MAXLMUL-1:0]     dst
);
    localparam int VB  = VLEN / 8;
    localparam int SB  = SLEN / 8;
    localparam int NS  = VLEN / SLEN;
    localparam int GB  = VB * MAXLMUL;
    localparam int VBL = $clog2(VB);
    localparam int IW  = $clog2(GB);

    // Physical byte of a memory index at a given width and layout.
    function automatic int phys_of_mem(int m, int wl, int ll, bit ctg);
        int c, o, e, b, r, k;
        if (ctg) begin
            c = m / SB;
            o = m % SB;
            return ((c & ((1 << ll) - 1)) * VB) + ((c >> ll) * SB) + o;
        end
        e = m >> wl;
        b = m & ((1 << wl) - 1);
        r = e >> (VBL - wl);
        k = e & ((1 << (VBL - wl)) - 1);
        return (r * VB) + ((k % NS) * SB) + ((k / NS) << wl) + b;
    endfunction

    // Memory index held by a physical byte at a given width and layout.
    function automatic int mem_of_phys(int q, int wl, int ll, bit ctg);
        int r, y, s, z, p, b, k, e;
        r = q / VB;
        y = q % VB;
        s = y / SB;
        z = y % SB;
        if (ctg) begin
            return (((s << ll) + r) * SB) + z;
        end
        p = z >> wl;
        b = z & ((1 << wl) - 1);
        k = (p * NS) + s;
        e = (r << (VBL - wl)) + k;
        return (e << wl) + b;
    endfunction

    for (genvar q = 0; q < GB; q++) begin : g_byte
        logic [IW-1:0] pick;
        logic          live;

        // Select the source byte and decide whether this register is in the group.
        always_comb begin
            pick = IW'(phys_of_mem(mem_of_phys(q, int'(cfg.dst_wl), int'(cfg.grp_ll), cfg.contig),
                                   int'(cfg.src_wl), int'(cfg.grp_ll), cfg.contig));
            live = (q / VB) < (1 << int'(cfg.grp_ll));
        end

        assign dst[q*8 +: 8] = live ? src[{pick, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/scu_hold_stage.sv
// One-entry valid/ready register stage with full throughput.
// Assumes the consumer may hold out_ready low for any number of cycles.
module scu_hold_stage #(
    parameter int W = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    // Track whether the stage holds a beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    // Capture a beat only on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid && in_ready) begin
            out_data <= in_data;
        end
    end
endmodule

// File: rtl/slice_cast_unit.sv
// Top of the cast unit: decode, byte permutation, output register.
// One register group per beat, result one cycle after acceptance.
// Assumes SLEN divides VLEN and ELEN is 8, 16, 32 or 64 bits wide.
module slice_cast_unit
    import slice_cast_pkg::*;
#(
    parameter int VLEN    = 256,
    parameter int SLEN    = 128,
    parameter int ELEN    = 32,
    parameter int MAXLMUL = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              in_src_eew,
    input  logic [1:0]              in_dst_eew,
    input  logic [1:0]              in_lmul,
    input  logic                    in_contig,
    input  logic [VLEN*MAXLMUL-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [VLEN*MAXLMUL-1:0] out_data
);
    localparam int GW     = VLEN * MAXLMUL;
    localparam int MAX_WL = $clog2(ELEN / 8);
    localparam int MAX_LL = $clog2(MAXLMUL);

    scu_cfg_t          cfg;
    logic [GW-1:0]     cast_data;

    scu_cfg_decode #(
        .MAX_WL (MAX_WL),
        .MAX_LL (MAX_LL)
    ) u_decode (
        .src_code (in_src_eew),
        .dst_code (in_dst_eew),
        .grp_code (in_lmul),
        .contig   (in_contig),
        .cfg      (cfg)
    );

    scu_byte_map #(
        .VLEN    (VLEN),
        .SLEN    (SLEN),
        .MAXLMUL (MAXLMUL)
    ) u_map (
        .cfg (cfg),
        .src (in_data),
        .dst (cast_data)
    );

    scu_hold_stage #(
        .W (GW)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (cast_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: rtl/scu_checker.sv
// Protocol and data properties of the cast unit, bound to its top.
module scu_checker #(
    parameter int GW = 1024,
    parameter int VB = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [1:0]    in_src_eew,
    input logic [1:0]    in_dst_eew,
    input logic [1:0]    in_lmul,
    input logic [GW-1:0] in_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [GW-1:0] out_data
);
    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R9
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R4
    same_width_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_src_eew == in_dst_eew) && in_lmul[1])
        |=> (out_data == $past(in_data)));

    // R6
    short_group_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_lmul == 2'd0))
        |=> (out_data[GW-1:VB*8] == '0));
endmodule

bind slice_cast_unit scu_checker #(
    .GW (VLEN * MAXLMUL),
    .VB (VLEN / 8)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_src_eew (in_src_eew),
    .in_dst_eew (in_dst_eew),
    .in_lmul    (in_lmul),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
);

// File: tb/tb_slice_cast_unit.sv
module tb_slice_cast_unit;
    localparam int VLEN = 256, SLEN = 128, ELEN = 32, MAXLMUL = 4;
    localparam int VB = VLEN / 8, GB = VB * MAXLMUL, GW = VLEN * MAXLMUL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          in_valid = 1'b0, out_ready = 1'b1, in_contig = 1'b0;
    logic [1:0]    in_src_eew = '0, in_dst_eew = '0, in_lmul = '0;
    logic [GW-1:0] in_data = '0;
    logic          in_ready, out_valid, f_in_ready, f_out_valid;
    logic [GW-1:0] out_data, f_out_data;

    int checks = 0, errors = 0;

    slice_cast_unit #(.VLEN(VLEN), .SLEN(SLEN), .ELEN(ELEN), .MAXLMUL(MAXLMUL)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src_eew(in_src_eew), .in_dst_eew(in_dst_eew), .in_lmul(in_lmul),
        .in_contig(in_contig), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data));

    slice_cast_unit #(.VLEN(VLEN), .SLEN(VLEN), .ELEN(ELEN), .MAXLMUL(MAXLMUL)) dut_flat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(f_in_ready),
        .in_src_eew(in_src_eew), .in_dst_eew(in_dst_eew), .in_lmul(in_lmul),
        .in_contig(in_contig), .in_data(in_data), .out_valid(f_out_valid),
        .out_ready(out_ready), .out_data(f_out_data));

    task automatic chk(bit ok, string req, logic [GW-1:0] act, logic [GW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Forward placement of element e, byte b, in either layout.
    function automatic int place(int e, int b, int w, int regs, bit ctg, int sb);
        int epr = VB / w;
        int ns  = VB / sb;
        if (ctg) begin
            int eps   = sb / w;
            int chunk = e / eps;
            return (chunk % regs) * VB + (chunk / regs) * sb + (e % eps) * w + b;
        end else begin
            int r = e / epr;
            int k = e % epr;
            return r * VB + (k % ns) * sb + (k / ns) * w + b;
        end
    endfunction

    // Store at source width, reload at destination width.
    function automatic logic [GW-1:0] model(logic [GW-1:0] d, logic [1:0] sc, logic [1:0] dc,
                                            logic [1:0] lc, bit ctg);
        int sw   = 1 << ((sc == 2'd3) ? 2 : int'(sc));
        int dw   = 1 << ((dc == 2'd3) ? 2 : int'(dc));
        int regs = 1 << ((lc == 2'd3) ? 2 : int'(lc));
        logic [7:0]    mem [GB];
        logic [GW-1:0] o = '0;
        for (int e = 0; e < regs * VB / sw; e++)
            for (int b = 0; b < sw; b++)
                mem[e*sw + b] = d[place(e, b, sw, regs, ctg, SLEN/8)*8 +: 8];
        for (int e = 0; e < regs * VB / dw; e++)
            for (int b = 0; b < dw; b++)
                o[place(e, b, dw, regs, ctg, SLEN/8)*8 +: 8] = mem[e*dw + b];
        return o;
    endfunction

    function automatic logic [GW-1:0] pat(int seed);
        logic [GW-1:0] v;
        for (int i = 0; i < GB; i++) v[i*8 +: 8] = 8'(i * 29 + seed * 71 + (i >> 2) * seed);
        return v;
    endfunction

    function automatic logic [GW-1:0] keep_regs(logic [GW-1:0] d, int regs);
        logic [GW-1:0] v = d;
        for (int i = regs * VB; i < GB; i++) v[i*8 +: 8] = 8'h00;
        return v;
    endfunction

    // Send one beat on an empty pipe and return what appears one cycle later.
    task automatic one_beat(logic [GW-1:0] d, logic [1:0] sc, logic [1:0] dc, logic [1:0] lc,
                            bit ctg, string req, output logic [GW-1:0] got,
                            output logic [GW-1:0] got_flat);
        @(negedge clk);
        in_data = d; in_src_eew = sc; in_dst_eew = dc; in_lmul = lc; in_contig = ctg;
        in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {req, " R9 latency"}, GW'(out_valid), GW'(1));
        got = out_data;
        got_flat = f_out_data;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", GW'(out_valid), GW'(0));
        chk(in_ready == 1'b1, "R1 in_ready in reset", GW'(in_ready), GW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", GW'(out_valid), GW'(0));
    endtask

    task automatic t_known();
        logic [GW-1:0] d, got, gf;
        for (int q = 0; q < GB; q++) begin
            int r = q / VB;
            int y = q % VB;
            d[q*8 +: 8] = 8'(r * 32 + 2 * (y % 16) + y / 16);
        end
        one_beat(d, 2'd0, 2'd2, 2'd2, 1'b0, "R2", got, gf);
        chk(got[0*8 +: 8] == 8'h00, "R2 byte0", GW'(got[0*8 +: 8]), GW'(8'h00));
        chk(got[4*8 +: 8] == 8'h08, "R2 elem2 low slice", GW'(got[4*8 +: 8]), GW'(8'h08));
        chk(got[16*8 +: 8] == 8'h04, "R2 elem1 high slice", GW'(got[16*8 +: 8]), GW'(8'h04));
        chk(got[20*8 +: 8] == 8'h0C, "R2 elem3 high slice", GW'(got[20*8 +: 8]), GW'(8'h0C));
        chk(got[96*8 +: 8] == 8'h60, "R2 elem 0x18 last reg", GW'(got[96*8 +: 8]), GW'(8'h60));
        chk(got[112*8 +: 8] == 8'h64, "R2 elem 0x19 last reg", GW'(got[112*8 +: 8]), GW'(8'h64));
        chk(got == model(d, 2'd0, 2'd2, 2'd2, 1'b0), "R3 known pattern", got,
            model(d, 2'd0, 2'd2, 2'd2, 1'b0));
    endtask

    task automatic t_all_pairs();
        logic [GW-1:0] d, got, gf, exp;
        for (int s = 0; s < 3; s++) begin
            for (int t = 0; t < 3; t++) begin
                d = pat(s * 3 + t + 1);
                one_beat(d, 2'(s), 2'(t), 2'd2, 1'b0, "R3", got, gf);
                exp = model(d, 2'(s), 2'(t), 2'd2, 1'b0);
                chk(got == exp, "R3 width pair", got, exp);
                if (s == t) chk(got == d, "R4 same width identity", got, d);
            end
        end
    endtask

    task automatic t_contig();
        logic [GW-1:0] d, got, gf, exp;
        for (int s = 0; s < 3; s++) begin
            d = pat(20 + s);
            one_beat(d, 2'(s), 2'(2 - s), 2'd2, 1'b1, "R5", got, gf);
            exp = model(d, 2'(s), 2'(2 - s), 2'd2, 1'b1);
            chk(got == exp, "R5 packed layout model", got, exp);
            chk(got == d, "R5 packed layout identity", got, d);
        end
    endtask

    task automatic t_short_group();
        logic [GW-1:0] d, got, gf, exp;
        for (int l = 0; l < 2; l++) begin
            d = pat(30 + l);
            one_beat(d, 2'd0, 2'd2, 2'(l), 1'b0, "R6", got, gf);
            exp = model(d, 2'd0, 2'd2, 2'(l), 1'b0);
            chk(got == exp, "R6 short group cast", got, exp);
            chk(got == keep_regs(got, 1 << l), "R6 unused registers zero", got, keep_regs(got, 1 << l));
        end
        d = pat(33);
        one_beat(d, 2'd1, 2'd0, 2'd0, 1'b1, "R6", got, gf);
        chk(got == keep_regs(d, 1), "R6 packed single register", got, keep_regs(d, 1));
    endtask

    task automatic t_reserved();
        logic [GW-1:0] d, got, gf, exp;
        d = pat(40);
        one_beat(d, 2'd3, 2'd0, 2'd3, 1'b0, "R7", got, gf);
        exp = model(d, 2'd2, 2'd0, 2'd2, 1'b0);
        chk(got == exp, "R7 reserved width and group codes", got, exp);
        d = pat(41);
        one_beat(d, 2'd1, 2'd3, 2'd2, 1'b0, "R7", got, gf);
        exp = model(d, 2'd1, 2'd2, 2'd2, 1'b0);
        chk(got == exp, "R7 reserved destination code", got, exp);
    endtask

    task automatic t_flat();
        logic [GW-1:0] d, got, gf;
        d = pat(50);
        one_beat(d, 2'd0, 2'd2, 2'd2, 1'b0, "R8", got, gf);
        chk(gf == d, "R8 single slice identity", gf, d);
        d = pat(51);
        one_beat(d, 2'd2, 2'd1, 2'd1, 1'b0, "R8", got, gf);
        chk(gf == keep_regs(d, 2), "R8 single slice two registers", gf, keep_regs(d, 2));
    endtask

    // Stream N beats; stall_mode selects an irregular out_ready.
    task automatic t_stream(bit stall_mode);
        localparam int N = 8;
        logic [GW-1:0] bd [N];
        logic [GW-1:0] ex [N];
        logic [1:0]    sc [N];
        logic [1:0]    dc [N];
        int tx = 0, rx = 0, cyc = 0, stalls = 0;
        for (int i = 0; i < N; i++) begin
            bd[i] = pat(60 + i + (stall_mode ? 10 : 0));
            sc[i] = 2'(i % 3);
            dc[i] = 2'((i + 1) % 3);
            ex[i] = model(bd[i], sc[i], dc[i], 2'd2, 1'b0);
        end
        while (rx < N && cyc < 200) begin
            @(negedge clk);
            in_valid = (tx < N);
            if (tx < N) begin
                in_data = bd[tx]; in_src_eew = sc[tx]; in_dst_eew = dc[tx];
                in_lmul = 2'd2; in_contig = 1'b0;
            end
            out_ready = stall_mode ? (((cyc * 5) % 3) != 0) : 1'b1;
            #1;
            if (out_valid && out_ready) begin
                chk(out_data == ex[rx], "R10 stream order and data", out_data, ex[rx]);
                rx++;
            end
            if (in_valid && !in_ready) stalls++;
            if (in_valid && in_ready) tx++;
            cyc++;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        chk(rx == N, "R10 beats delivered", GW'(rx), GW'(N));
        if (!stall_mode) begin
            chk(stalls == 0, "R9 one beat per cycle", GW'(stalls), GW'(0));
            chk(cyc == N + 1, "R9 stream cycles", GW'(cyc), GW'(N + 1));
        end else begin
            chk(stalls > 0, "R10 back-pressure reached input", GW'(stalls), GW'(1));
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_known();
        t_all_pairs();
        t_contig();
        t_short_group();
        t_reserved();
        t_flat();
        t_stream(1'b0);
        t_stream(1'b1);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule